// File: doc/BRIEF.md
# GPIO Bank with Edge Status

This block is one general-purpose I/O bank of up to eight pins. Software reaches it through byte-wide registers on a plain register bus: a 3-bit address, a write strobe, a read strobe and 8-bit write and read data. Each pin has its own settings for direction, polarity inversion, drive style (push-pull or open-drain) and a function mask that takes the pin away from GPIO use. The bank drives a pad model with per-pin output value, output-enable and open-drain select signals, and it takes the pad levels back in.

Pad inputs pass through a two-flop synchronizer. Any level change on a usable pin of an enabled bank sets that pin's bit in an edge status register. Reading the status register returns the captured bits and clears them. If a new edge arrives in the same cycle as the clearing read, the new edge is kept. A single bank-enable bit gates driving, data reads and edge capture for the whole bank. The pin count is a parameter, so a reduced bank with only one pin uses the same code.

The bus is control traffic, so it has no handshake. A write takes effect at the clock edge where `bus_wr` is high. A read loads `bus_rdata` at the clock edge where `bus_rd` is high. The value stays on `bus_rdata` until the next read.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register holds its reset value and no pad is driven. The reset values are: enable 0, direction all ones (inputs), inversion 0, mode all ones (open-drain), function mask 0, status 0. `pad_od` equals the mode register.
- R2: The register map is: 0 enable (bit 0), 1 direction (1 = input), 2 data, 3 inversion, 4 status, 5 mode (1 = open-drain, 0 = push-pull), 6 function mask (1 = not usable). A write to address 0, 1, 3, 5 or 6 can be read back, with bits above the pin count read as 0. Address 7 reads 0. Writes to status are ignored.
- R3: A read of the data register returns, for each usable pin of an enabled bank, the synchronized pad level XOR the pin's inversion bit.
- R4: For a push-pull pin that is driven, `pad_oe` is 1 and `pad_out` equals the output latch XOR inversion. A pin is driven when the bank is enabled, the pin is usable and its direction bit is 0.
- R5: For an open-drain pin that is driven, `pad_oe` is 1 only when the inverted output value is 0, and `pad_out` is 0.
- R6: A pin whose direction bit is 1 is never driven.
- R7: A pin whose function-mask bit is set is never driven, reads 0 in the data register, and captures no edges.
- R8: While the enable bit is 0, no pin is driven, data reads return 0, and no edges are captured.
- R9: A pad level change sets the pin's status bit at the third rising edge after the change. A status read returns the bits and clears them.
- R10: When a status bit is set in the same cycle as a clearing status read, the read returns the old value and the bit stays set.
- R11: A write to the data register loads the output latch, and the pads follow at the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, loaded at a read edge |
| pad_in | input | NPINS | Pad levels |
| pad_out | output | NPINS | Value driven to pad |
| pad_oe | output | NPINS | Pad output-enable |
| pad_od | output | NPINS | Open-drain select per pin |

## Verification
Edge capture and the clearing status read can land on the same clock edge. The bench provokes this by changing a pad level and then issuing the status read exactly two falling edges later, so that the read strobe meets the edge where the synchronized change reaches the status register. That read must return the old value, which is zero. A second read must then return the new bit, which shows that the set won over the clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_AW = 3;
  localparam int BUS_DW = 8;

  typedef enum logic [BUS_AW-1:0] {
    REG_ENABLE = 3'd0,
    REG_DIR    = 3'd1,
    REG_DATA   = 3'd2,
    REG_INV    = 3'd3,
    REG_STAT   = 3'd4,
    REG_MODE   = 3'd5,
    REG_FUNC   = 3'd6,
    REG_SPARE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] change
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level  = sync_q;
  assign change = sync_q ^ prev_q;
endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive (
  input  logic en,
  input  logic masked,
  input  logic is_input,
  input  logic invert,
  input  logic open_drain,
  input  logic latch,
  output logic pad_out,
  output logic pad_oe
);
  logic active, lvl;

  always_comb begin
    active  = en & ~masked & ~is_input;
    lvl     = latch ^ invert;
    pad_oe  = active & (~open_drain | ~lvl);
    pad_out = active & ~open_drain & lvl;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_DW-1:0] wdata,
  output logic [BUS_DW-1:0] rdata,
  input  logic [NPINS-1:0]  level,
  input  logic [NPINS-1:0]  cap,
  output logic              en_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  inv_q,
  output logic [NPINS-1:0]  odm_q,
  output logic [NPINS-1:0]  func_q,
  output logic [NPINS-1:0]  latch_q,
  output logic [NPINS-1:0]  status_q
);
  localparam logic [NPINS-1:0] ALL_ONES = '1;

  function automatic logic [BUS_DW-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_DW-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  logic [NPINS-1:0]  pin_view;
  logic [BUS_DW-1:0] rd_mux;
  logic              stat_clr;

  always_comb begin
    pin_view = en_q ? ((level ^ inv_q) & ~func_q) : '0;
    stat_clr = rd && (reg_sel_e'(addr) == REG_STAT);
    case (reg_sel_e'(addr))
      REG_ENABLE: rd_mux = {{(BUS_DW-1){1'b0}}, en_q};
      REG_DIR:    rd_mux = widen(dir_q);
      REG_DATA:   rd_mux = widen(pin_view);
      REG_INV:    rd_mux = widen(inv_q);
      REG_STAT:   rd_mux = widen(status_q);
      REG_MODE:   rd_mux = widen(odm_q);
      REG_FUNC:   rd_mux = widen(func_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      dir_q    <= ALL_ONES;
      inv_q    <= '0;
      odm_q    <= ALL_ONES;
      func_q   <= '0;
      latch_q  <= '0;
      status_q <= '0;
      rdata    <= '0;
    end else begin
      if (wr) begin
        case (reg_sel_e'(addr))
          REG_ENABLE: en_q    <= wdata[0];
          REG_DIR:    dir_q   <= wdata[NPINS-1:0];
          REG_DATA:   latch_q <= wdata[NPINS-1:0];
          REG_INV:    inv_q   <= wdata[NPINS-1:0];
          REG_MODE:   odm_q   <= wdata[NPINS-1:0];
          REG_FUNC:   func_q  <= wdata[NPINS-1:0];
          default:    ;
        endcase
      end
      status_q <= (stat_clr ? '0 : status_q) | cap;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_od
);
  logic             en_q;
  logic [NPINS-1:0] dir_q, inv_q, odm_q, func_q, latch_q, status_q;
  logic [NPINS-1:0] level, change, cap;

  gpio_bank_sync #(.N(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pad_in),
    .level  (level),
    .change (change)
  );

  assign cap = en_q ? (change & ~func_q) : '0;

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .level    (level),
    .cap      (cap),
    .en_q     (en_q),
    .dir_q    (dir_q),
    .inv_q    (inv_q),
    .odm_q    (odm_q),
    .func_q   (func_q),
    .latch_q  (latch_q),
    .status_q (status_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_bank_drive u_drv (
      .en         (en_q),
      .masked     (func_q[i]),
      .is_input   (dir_q[i]),
      .invert     (inv_q[i]),
      .open_drain (odm_q[i]),
      .latch      (latch_q[i]),
      .pad_out    (pad_out[i]),
      .pad_oe     (pad_oe[i])
    );
  end

  assign pad_od = odm_q;
endmodule

// File: rtl/gpio_bank_sva.sv
module gpio_bank_sva
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_od,
  input logic              en,
  input logic [NPINS-1:0]  dir,
  input logic [NPINS-1:0]  func,
  input logic [NPINS-1:0]  cap,
  input logic [NPINS-1:0]  status
);
  a_r6_input_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir) == '0);

  a_r7_masked_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & func) == '0);

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pad_oe == '0 && cap == '0));

  a_r5_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_od & pad_out) == '0);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != '0) |=> ((status & $past(cap)) == $past(cap)));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_STAT && cap == '0) |=> (status == '0));
endmodule

bind gpio_bank gpio_bank_sva #(.NPINS(NPINS)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pad_od   (pad_od),
  .en       (en_q),
  .dir      (dir_q),
  .func     (func_q),
  .cap      (cap),
  .status   (status_q)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_od;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  gpio_bank #(.NPINS(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: pops one expected item per read strobe seen at a rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("monitor-underflow", bus_rdata, 8'h00);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_od", pad_od, 8'hFF);
    rd_reg(3'd0, 8'h00, "R1 enable");
    rd_reg(3'd1, 8'hFF, "R1 dir");
    rd_reg(3'd3, 8'h00, "R1 inv");
    rd_reg(3'd4, 8'h00, "R1 status");
    rd_reg(3'd5, 8'hFF, "R1 mode");
    rd_reg(3'd6, 8'h00, "R1 func");
    // R2 register readback
    wr_reg(3'd0, 8'hFF);
    wr_reg(3'd1, 8'h0F);
    wr_reg(3'd3, 8'h30);
    wr_reg(3'd5, 8'hA0);
    wr_reg(3'd4, 8'hFF);
    rd_reg(3'd0, 8'h01, "R2 enable");
    rd_reg(3'd1, 8'h0F, "R2 dir");
    rd_reg(3'd3, 8'h30, "R2 inv");
    rd_reg(3'd5, 8'hA0, "R2 mode");
    rd_reg(3'd4, 8'h00, "R2 status write ignored");
    rd_reg(3'd7, 8'h00, "R2 spare");
    // R11/R4/R5 output latch: level = 5A^30 = 6A
    wr_reg(3'd2, 8'h5A);
    check("R4 R5 pad_oe", pad_oe, 8'hD0);
    check("R4 pad_out", pad_out, 8'h40);
    check("R5 pad_od", pad_od, 8'hA0);
    wr_reg(3'd2, 8'hA5);
    check("R11 pad_oe", pad_oe, 8'h70);
    check("R11 pad_out", pad_out, 8'h10);
    // R3/R9 input read and edge capture
    pad_in = 8'h96;
    idle(4);
    rd_reg(3'd2, 8'hA6, "R3 data");
    rd_reg(3'd4, 8'h96, "R9 status");
    rd_reg(3'd4, 8'h00, "R9 status cleared");
    // R7 function mask on pins 4 and 6
    wr_reg(3'd6, 8'h50);
    check("R7 pad_oe", pad_oe, 8'h20);
    check("R7 pad_out", pad_out, 8'h00);
    pad_in = 8'hFF;
    idle(4);
    rd_reg(3'd2, 8'h8F, "R7 data");
    rd_reg(3'd4, 8'h29, "R7 status");
    wr_reg(3'd6, 8'h00);
    // R6 all inputs
    wr_reg(3'd1, 8'hFF);
    check("R6 pad_oe", pad_oe, 8'h00);
    wr_reg(3'd1, 8'h0F);
    // R10 set coinciding with clearing read
    pad_in = 8'hFE;
    idle(2);
    rd_reg(3'd4, 8'h00, "R10 read at set edge");
    rd_reg(3'd4, 8'h01, "R10 bit kept");
    // R8 bank disabled
    wr_reg(3'd0, 8'h00);
    check("R8 pad_oe", pad_oe, 8'h00);
    rd_reg(3'd2, 8'h00, "R8 data");
    pad_in = 8'h00;
    idle(4);
    wr_reg(3'd0, 8'h01);
    rd_reg(3'd4, 8'h00, "R8 no capture");
    idle(3);
    check("queue drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule